// File: doc/BRIEF.md
# Renaming reservation-station pool

This block sits between an in-order instruction queue and a single functional unit. It keeps a small pool of reservation stations and a rename table that records, for every architectural register, whether a station still has to produce its value and, if so, which one. When an instruction is issued, the block allocates a free station. Each source operand then either gets its value straight away or gets the tag of the station that will produce it. The destination register is then mapped to the new station, so later readers wait on that station and never see a stale value.

Results come back on a broadcast result bus that carries a station tag and a value. Every station waiting on that tag picks up the value in the same cycle. The architectural register file is written only when the broadcasting station is still the newest writer of the register. A result whose tag arrives on the bus in the same cycle as a consumer is issued goes straight into the new station. Among the stations that hold both operands, the oldest by allocation order is sent to the functional unit. A station becomes free in the cycle its result is broadcast.

Top module: `rs_rename_pool`

## Requirements
- R1: After reset every station is free, `issue_ready` is 1, `disp_valid` is 0, no register is pending, and architectural register r holds the value r.
- R2: An instruction is accepted on a clock edge where `issue_valid` and `issue_ready` are both 1. `issue_ready` is 1 exactly when at least one station is free, and `issue_tag` names the free station with the lowest index. An instruction offered while all stations are busy is not taken, and the architectural outcome is the same as if it had never been offered.
- R3: A source register with no pending producer takes its value from the register file at issue. A source whose register is pending takes the producer's tag and later captures the value broadcast with that tag.
- R4: If the producer of a source broadcasts on the clock edge where the consumer is issued, the consumer captures that broadcast value directly.
- R5: A station is presented on `disp_valid` only when both of its operands are present. `disp_op` equals the issued operation code, and `disp_a`/`disp_b` equal the values the first/second source registers hold in sequential program order.
- R6: When several stations hold both operands, the one allocated earliest is presented first, whatever its index.
- R7: Each allocation of a station is presented to the functional unit exactly once.
- R8: A station whose tag is broadcast becomes free on that clock edge, so `issue_ready` is 1 in the next cycle.
- R9: The register file is written with a broadcast value only when the broadcast tag is the register's current producer. A broadcast from an older writer of the same register leaves the register unchanged. After all results have been broadcast, each register holds its sequential-order value and is not pending.
- R10: An instruction whose source and destination are the same register reads the mapping that was in place before its own rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is offered at the head of the in-order queue |
| issue_op | input | OP_W | Operation code passed through to the unit |
| issue_dst | input | REG_W | Destination architectural register |
| issue_src1 | input | REG_W | First source architectural register |
| issue_src2 | input | REG_W | Second source architectural register |
| issue_ready | output | 1 | A station is free; an offered instruction is taken |
| issue_tag | output | TAG_W | Station that the offered instruction would occupy |
| disp_valid | output | 1 | A station is sent to the unit this cycle |
| disp_tag | output | TAG_W | Tag of the station sent |
| disp_op | output | OP_W | Operation of the station sent |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |
| cdb_valid | input | 1 | A result is on the broadcast bus |
| cdb_tag | input | TAG_W | Tag of the station that produced the result |
| cdb_value | input | DATA_W | Result value |
| peek_addr | input | REG_W | Architectural register to observe |
| peek_data | output | DATA_W | Committed value of that register |
| peek_pending | output | 1 | That register still waits on a producer |

## Verification
Independent instructions show the register-file read path. A chain of instructions held behind an unreturned result shows that waiting stations stay quiet and then capture the broadcast value. A broadcast timed into the cycle of issue tells a correct bypass apart from a missed capture. Two waiters arranged so that the older one has the higher index tell age order apart from index priority. Filling the pool shows the stall and its release. Two writers of one register whose results return newest first show the stale-write guard. A long random run, with results returned in shuffled order, compares every dispatched operand and the final register file with a sequential model of the program.

// File: rtl/rs_pkg.sv
// Shared types for the renaming reservation-station pool.
// Assumes nothing beyond plain SystemVerilog packages.
package rs_pkg;
    // Where a source operand comes from at issue time
    typedef enum logic [1:0] {
        SRC_RF     = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_WAIT   = 2'd2
    } src_kind_e;
endpackage

// File: rtl/rs_rename_table.sv
// Rename table plus architectural register file.
// Maps each register to its pending producer tag, resolves the two issue
// sources (register file, same-cycle broadcast, or wait on a tag), and
// commits a broadcast only when the tag is still the newest producer.
// Assumes NUM_ARCH is a power of two so every address is a legal index.
module rs_rename_table import rs_pkg::*; #(
    parameter int  NUM_ARCH = 8,
    parameter int  NUM_ST   = 4,
    parameter int  DATA_W   = 16,
    localparam int REG_W    = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1,
    localparam int TAG_W    = (NUM_ST > 1) ? $clog2(NUM_ST) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  s1_addr,
    input  logic [REG_W-1:0]  s2_addr,
    output src_kind_e         s1_kind,
    output logic [DATA_W-1:0] s1_val,
    output logic [TAG_W-1:0]  s1_tag,
    output src_kind_e         s2_kind,
    output logic [DATA_W-1:0] s2_val,
    output logic [TAG_W-1:0]  s2_tag,
    input  logic              ren_en,
    input  logic [REG_W-1:0]  ren_addr,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic [REG_W-1:0]  peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic              peek_pending
);
    logic [DATA_W-1:0] rf   [NUM_ARCH];
    logic [TAG_W-1:0]  ptag [NUM_ARCH];
    logic [NUM_ARCH-1:0] pend;

    logic [REG_W-1:0]  sa [2];
    src_kind_e         sk [2];
    logic [DATA_W-1:0] sv [2];
    logic [TAG_W-1:0]  st [2];

    assign sa[0] = s1_addr;
    assign sa[1] = s2_addr;

    // Resolve each source against the mapping in place before this issue
    always_comb begin
        for (int k = 0; k < 2; k++) begin
            st[k] = ptag[sa[k]];
            if (pend[sa[k]]) begin
                if (cdb_valid && (cdb_tag == ptag[sa[k]])) begin
                    sk[k] = SRC_BYPASS;
                    sv[k] = cdb_value;
                end else begin
                    sk[k] = SRC_WAIT;
                    sv[k] = '0;
                end
            end else begin
                sk[k] = SRC_RF;
                sv[k] = rf[sa[k]];
            end
        end
    end

    assign s1_kind = sk[0];
    assign s1_val  = sv[0];
    assign s1_tag  = st[0];
    assign s2_kind = sk[1];
    assign s2_val  = sv[1];
    assign s2_tag  = st[1];

    generate
        for (genvar r = 0; r < NUM_ARCH; r++) begin : g_reg
            logic newest_hit;
            assign newest_hit = cdb_valid && pend[r] && (ptag[r] == cdb_tag);

            // Track the producer of register r and commit its newest result
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend[r] <= 1'b0;
                    ptag[r] <= '0;
                    rf[r]   <= DATA_W'(r);
                end else begin
                    if (newest_hit) begin
                        rf[r] <= cdb_value;
                    end
                    if (ren_en && (ren_addr == REG_W'(r))) begin
                        pend[r] <= 1'b1;
                        ptag[r] <= ren_tag;
                    end else if (newest_hit) begin
                        pend[r] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

    assign peek_data    = rf[peek_addr];
    assign peek_pending = pend[peek_addr];
endmodule

// File: rtl/rs_station.sv
// One reservation station: holds the operation and, per operand, either
// its value or the tag it waits on. Snoops the result bus for waiting
// operands and frees itself when its own tag is broadcast.
// Assumes the issue logic only allocates it while it is free and that its
// own result is broadcast only after it has been dispatched.
module rs_station #(
    parameter int  IDX    = 0,
    parameter int  NUM_ST = 4,
    parameter int  DATA_W = 16,
    parameter int  OP_W   = 2,
    localparam int TAG_W  = (NUM_ST > 1) ? $clog2(NUM_ST) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   a_op,
    input  logic              a_j_wait,
    input  logic [TAG_W-1:0]  a_j_tag,
    input  logic [DATA_W-1:0] a_j_val,
    input  logic              a_k_wait,
    input  logic [TAG_W-1:0]  a_k_tag,
    input  logic [DATA_W-1:0] a_k_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk
);
    logic             sent;
    logic             wj, wk;
    logic [TAG_W-1:0] qj, qk;

    // Allocation, operand capture, dispatch marking and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sent <= 1'b0;
            wj   <= 1'b0;
            wk   <= 1'b0;
            qj   <= '0;
            qk   <= '0;
            op   <= '0;
            vj   <= '0;
            vk   <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            sent <= 1'b0;
            op   <= a_op;
            wj   <= a_j_wait;
            qj   <= a_j_tag;
            vj   <= a_j_val;
            wk   <= a_k_wait;
            qk   <= a_k_tag;
            vk   <= a_k_val;
        end else begin
            if (busy && cdb_valid && (cdb_tag == TAG_W'(IDX))) begin
                busy <= 1'b0;
            end
            if (wj && cdb_valid && (cdb_tag == qj)) begin
                vj <= cdb_value;
                wj <= 1'b0;
            end
            if (wk && cdb_valid && (cdb_tag == qk)) begin
                vk <= cdb_value;
                wk <= 1'b0;
            end
            if (grant) begin
                sent <= 1'b1;
            end
        end
    end

    assign ready = busy && !sent && !wj && !wk;
endmodule

// File: rtl/rs_age_pick.sv
// Oldest-first selector over N requesters using an age matrix.
// older[i][j] set means station i was allocated before station j.
// Assumes at most one allocation per cycle and only into a free slot.
module rs_age_pick #(
    parameter int  N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     alloc,
    input  logic [N-1:0]     busy,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [N-1:0] older [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_row
            // Row i: a fresh entry is younger than all; others age behind it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    older[i] <= '0;
                end else if (alloc[i]) begin
                    older[i] <= '0;
                end else begin
                    for (int j = 0; j < N; j++) begin
                        if (alloc[j]) begin
                            older[i][j] <= busy[i];
                        end
                    end
                end
            end
        end
    endgenerate

    // Grant a requester when no other requester is older than it
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && older[j][i]) begin
                    blocked = 1'b1;
                end
            end
            grant[i] = req[i] && !blocked;
        end
    end

    // Encode the granted index
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_rename_pool.sv
// Pool of renaming reservation stations in front of one functional unit.
// Allocates the lowest free station at issue, renames the destination to
// it, resolves sources through the rename table, and dispatches the oldest
// station with both operands to the unit. The unit is assumed to accept one
// dispatch per cycle and to return each result once on the broadcast bus.
module rs_rename_pool import rs_pkg::*; #(
    parameter int  NUM_ST   = 4,
    parameter int  NUM_ARCH = 8,
    parameter int  DATA_W   = 16,
    parameter int  OP_W     = 2,
    localparam int TAG_W    = (NUM_ST > 1) ? $clog2(NUM_ST) : 1,
    localparam int REG_W    = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [OP_W-1:0]   issue_op,
    input  logic [REG_W-1:0]  issue_dst,
    input  logic [REG_W-1:0]  issue_src1,
    input  logic [REG_W-1:0]  issue_src2,
    output logic              issue_ready,
    output logic [TAG_W-1:0]  issue_tag,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic [REG_W-1:0]  peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic              peek_pending
);
    logic [NUM_ST-1:0] st_busy;
    logic [NUM_ST-1:0] st_ready;
    logic [NUM_ST-1:0] st_grant;
    logic [NUM_ST-1:0] alloc_vec;
    logic [OP_W-1:0]   st_op [NUM_ST];
    logic [DATA_W-1:0] st_vj [NUM_ST];
    logic [DATA_W-1:0] st_vk [NUM_ST];

    logic              fire;
    logic [TAG_W-1:0]  alloc_idx;
    logic              any_free;

    src_kind_e         s1_kind, s2_kind;
    logic [DATA_W-1:0] s1_val, s2_val;
    logic [TAG_W-1:0]  s1_tag, s2_tag;

    // Find the lowest-index free station
    always_comb begin
        alloc_idx = '0;
        any_free  = 1'b0;
        for (int i = NUM_ST - 1; i >= 0; i--) begin
            if (!st_busy[i]) begin
                alloc_idx = TAG_W'(i);
                any_free  = 1'b1;
            end
        end
    end

    assign issue_ready = any_free;
    assign issue_tag   = alloc_idx;
    assign fire        = issue_valid && any_free;

    rs_rename_table #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_ST   (NUM_ST),
        .DATA_W   (DATA_W)
    ) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .s1_addr      (issue_src1),
        .s2_addr      (issue_src2),
        .s1_kind      (s1_kind),
        .s1_val       (s1_val),
        .s1_tag       (s1_tag),
        .s2_kind      (s2_kind),
        .s2_val       (s2_val),
        .s2_tag       (s2_tag),
        .ren_en       (fire),
        .ren_addr     (issue_dst),
        .ren_tag      (alloc_idx),
        .cdb_valid    (cdb_valid),
        .cdb_tag      (cdb_tag),
        .cdb_value    (cdb_value),
        .peek_addr    (peek_addr),
        .peek_data    (peek_data),
        .peek_pending (peek_pending)
    );

    generate
        for (genvar i = 0; i < NUM_ST; i++) begin : g_st
            assign alloc_vec[i] = fire && (alloc_idx == TAG_W'(i));

            rs_station #(
                .IDX    (i),
                .NUM_ST (NUM_ST),
                .DATA_W (DATA_W),
                .OP_W   (OP_W)
            ) u_st (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc     (alloc_vec[i]),
                .a_op      (issue_op),
                .a_j_wait  (s1_kind == SRC_WAIT),
                .a_j_tag   (s1_tag),
                .a_j_val   (s1_val),
                .a_k_wait  (s2_kind == SRC_WAIT),
                .a_k_tag   (s2_tag),
                .a_k_val   (s2_val),
                .cdb_valid (cdb_valid),
                .cdb_tag   (cdb_tag),
                .cdb_value (cdb_value),
                .grant     (st_grant[i]),
                .busy      (st_busy[i]),
                .ready     (st_ready[i]),
                .op        (st_op[i]),
                .vj        (st_vj[i]),
                .vk        (st_vk[i])
            );
        end
    endgenerate

    rs_age_pick #(
        .N (NUM_ST)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (alloc_vec),
        .busy      (st_busy),
        .req       (st_ready),
        .grant     (st_grant),
        .gnt_valid (disp_valid),
        .gnt_idx   (disp_tag)
    );

    assign disp_op = st_op[disp_tag];
    assign disp_a  = st_vj[disp_tag];
    assign disp_b  = st_vk[disp_tag];
endmodule

// File: rtl/rs_rename_pool_chk.sv
// Assertion checker for rs_rename_pool, attached by bind below.
// Assumes synchronous active-low reset; all properties are off in reset.
module rs_rename_pool_chk #(
    parameter int  NUM_ST = 4,
    localparam int TAG_W  = (NUM_ST > 1) ? $clog2(NUM_ST) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic              issue_ready,
    input logic [TAG_W-1:0]  issue_tag,
    input logic              disp_valid,
    input logic [TAG_W-1:0]  disp_tag,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic [NUM_ST-1:0] busy,
    input logic [NUM_ST-1:0] grant
);
    // R2
    full_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy) == NUM_ST) |-> !issue_ready);

    // R2
    alloc_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready) |=> busy[$past(issue_tag)]);

    // R8
    free_on_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && busy[cdb_tag]) |=> !busy[$past(cdb_tag)]);

    // R7
    single_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !(disp_valid && (disp_tag == $past(disp_tag))));

    // R5
    dispatch_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> busy[disp_tag]);

    // R6
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

bind rs_rename_pool rs_rename_pool_chk #(.NUM_ST(NUM_ST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_tag   (issue_tag),
    .disp_valid  (disp_valid),
    .disp_tag    (disp_tag),
    .cdb_valid   (cdb_valid),
    .cdb_tag     (cdb_tag),
    .busy        (st_busy),
    .grant       (st_grant)
);

// File: tb/rs_rename_pool_tb.sv
// Bench: acts as instruction queue and functional unit, keeps a sequential
// model of the program and compares the block's outputs every cycle.
module rs_rename_pool_tb;
    localparam int NS = 4;
    localparam int NA = 8;
    localparam int DW = 16;
    localparam int OW = 2;
    localparam int TW = 2;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [OW-1:0] issue_op = '0;
    logic [RW-1:0] issue_dst = '0, issue_src1 = '0, issue_src2 = '0;
    logic          issue_ready;
    logic [TW-1:0] issue_tag;
    logic          disp_valid;
    logic [TW-1:0] disp_tag;
    logic [OW-1:0] disp_op;
    logic [DW-1:0] disp_a, disp_b;
    logic          cdb_valid = 1'b0;
    logic [TW-1:0] cdb_tag = '0;
    logic [DW-1:0] cdb_value = '0;
    logic [RW-1:0] peek_addr = '0;
    logic [DW-1:0] peek_data;
    logic          peek_pending;

    always #2 clk = ~clk;

    rs_rename_pool #(.NUM_ST(NS), .NUM_ARCH(NA), .DATA_W(DW), .OP_W(OW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_op(issue_op), .issue_dst(issue_dst),
        .issue_src1(issue_src1), .issue_src2(issue_src2),
        .issue_ready(issue_ready), .issue_tag(issue_tag),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .peek_addr(peek_addr), .peek_data(peek_data), .peek_pending(peek_pending)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [DW-1:0] arch [NA];
    logic [DW-1:0] ea [NS];
    logic [DW-1:0] eb [NS];
    logic [OW-1:0] eop [NS];
    logic [DW-1:0] pres [NS];
    bit inflight [NS];
    bit used [NS];
    bit pv [NS];
    int busy_cnt = 0;
    int want_first = -1;
    int last_tag = 0;

    function automatic logic [DW-1:0] alu(input logic [OW-1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            2'd0:    alu = a + b;
            2'd1:    alu = a - b;
            2'd2:    alu = a ^ b;
            default: alu = (a << 1) + b;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // One cycle: compare outputs, drive issue and broadcast, advance model
    task automatic tick(input bit iv, input logic [OW-1:0] op, input logic [RW-1:0] d,
                        input logic [RW-1:0] s1, input logic [RW-1:0] s2, input int bsel);
        bit rec;
        int rt;
        int et;
        int chosen;
        logic [DW-1:0] rr;
        rec = 0; rt = 0; rr = '0;
        // R2 R8: ready follows the number of occupied stations
        chk(issue_ready == (busy_cnt < NS), "R2 R8 ready", 32'(issue_ready), 32'(busy_cnt < NS));
        if (disp_valid) begin
            if (want_first >= 0) begin
                chk(int'(disp_tag) == want_first, "R6 oldest first", 32'(disp_tag), 32'(want_first));
                want_first = -1;
            end
            chk(inflight[disp_tag], "R7 dispatch once", 32'(disp_tag), 32'(1));
            chk(disp_op == eop[disp_tag], "R5 op", 32'(disp_op), 32'(eop[disp_tag]));
            chk(disp_a == ea[disp_tag], "R5 operand a", 32'(disp_a), 32'(ea[disp_tag]));
            chk(disp_b == eb[disp_tag], "R5 operand b", 32'(disp_b), 32'(eb[disp_tag]));
            rec = 1; rt = int'(disp_tag);
            rr = alu(disp_op, disp_a, disp_b);
            inflight[disp_tag] = 0;
        end
        issue_valid = iv; issue_op = op; issue_dst = d; issue_src1 = s1; issue_src2 = s2;
        if (iv && busy_cnt < NS) begin
            et = -1;
            for (int t = NS - 1; t >= 0; t--) if (!used[t]) et = t;
            chk(int'(issue_tag) == et, "R2 lowest free tag", 32'(issue_tag), 32'(et));
            ea[et] = arch[s1]; eb[et] = arch[s2]; eop[et] = op;
            arch[d] = alu(op, arch[s1], arch[s2]);
            inflight[et] = 1; used[et] = 1; busy_cnt++;
            last_tag = et;
        end
        chosen = -1;
        if (bsel >= 0 && bsel < NS) begin
            if (pv[bsel]) chosen = bsel;
        end else if (bsel == NS) begin
            int cnt;
            int k;
            cnt = 0;
            for (int t = 0; t < NS; t++) if (pv[t]) cnt++;
            if (cnt > 0) begin
                k = $urandom_range(cnt - 1);
                for (int t = 0; t < NS; t++) begin
                    if (pv[t]) begin
                        if (k == 0 && chosen < 0) chosen = t;
                        k--;
                    end
                end
            end
        end
        cdb_valid = 1'b0;
        if (chosen >= 0) begin
            cdb_valid = 1'b1; cdb_tag = TW'(chosen); cdb_value = pres[chosen];
            pv[chosen] = 0; used[chosen] = 0; busy_cnt--;
        end
        if (rec) begin
            pv[rt] = 1; pres[rt] = rr;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int bsel);
        tick(0, '0, '0, '0, '0, bsel);
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && busy_cnt > 0; i++) idle(NS);
        idle(-1);
        idle(-1);
    endtask

    task automatic peek_reg(input int r, input string req);
        peek_addr = RW'(r);
        #1;
        chk(peek_data == arch[r], req, 32'(peek_data), 32'(arch[r]));
    endtask

    task automatic peek_all(input string req);
        for (int r = 0; r < NA; r++) begin
            peek_reg(r, req);
            chk(!peek_pending, req, 32'(peek_pending), 32'(0));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int x0;
        int xa;
        for (int r = 0; r < NA; r++) arch[r] = DW'(r);
        for (int t = 0; t < NS; t++) begin
            inflight[t] = 0; used[t] = 0; pv[t] = 0;
            ea[t] = '0; eb[t] = '0; eop[t] = '0; pres[t] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(issue_ready == 1'b1, "R1 ready", 32'(issue_ready), 32'(1));
        chk(disp_valid == 1'b0, "R1 no dispatch", 32'(disp_valid), 32'(0));
        peek_all("R1 reset register value");

        // R3: register-file operands
        tick(1, 2'd0, 3'd2, 3'd3, 3'd4, -1);
        tick(1, 2'd3, 3'd1, 3'd5, 3'd6, -1);
        drain();
        peek_all("R3 committed results");

        // R3: waiting operand captured from the bus
        tick(1, 2'd1, 3'd5, 3'd1, 3'd2, -1);
        x0 = last_tag;
        tick(1, 2'd2, 3'd0, 3'd5, 3'd7, -1);
        idle(-1); idle(-1); idle(-1);
        idle(x0);
        drain();
        peek_all("R3 chained results");

        // R4: broadcast in the same cycle as the consumer issues
        tick(1, 2'd0, 3'd6, 3'd2, 3'd3, -1);
        x0 = last_tag;
        idle(-1);
        idle(-1);
        tick(1, 2'd3, 3'd4, 3'd6, 3'd6, x0);
        drain();
        peek_all("R4 bypass results");

        // R6: older waiter at the higher index is sent first
        tick(1, 2'd0, 3'd3, 3'd1, 3'd1, -1);
        x0 = last_tag;
        tick(1, 2'd1, 3'd7, 3'd2, 3'd4, -1);
        xa = last_tag;
        tick(1, 2'd0, 3'd2, 3'd7, 3'd0, -1);
        want_first = last_tag;
        idle(-1);
        idle(x0);
        tick(1, 2'd2, 3'd1, 3'd7, 3'd5, -1);
        idle(-1);
        idle(xa);
        idle(-1);
        chk(want_first == -1, "R6 older dispatch seen", 32'(want_first), 32'hffffffff);
        want_first = -1;
        drain();
        peek_all("R6 results");

        // R2 R8: fill the pool, offer while full, release one station
        for (int i = 0; i < NS; i++) tick(1, 2'(i), 3'(i), 3'(i + 1), 3'(i + 2), -1);
        tick(1, 2'd0, 3'd7, 3'd0, 3'd0, -1);
        tick(1, 2'd0, 3'd7, 3'd0, 3'd0, -1);
        chk(issue_ready == 1'b0, "R2 full stall", 32'(issue_ready), 32'(0));
        idle(0);
        chk(issue_ready == 1'b1, "R8 freed on broadcast", 32'(issue_ready), 32'(1));
        drain();
        peek_all("R2 results after stall");

        // R9: two writers of one register, newest result returns first
        tick(1, 2'd0, 3'd1, 3'd2, 3'd3, -1);
        x0 = last_tag;
        tick(1, 2'd3, 3'd1, 3'd4, 3'd5, -1);
        xa = last_tag;
        idle(-1); idle(-1);
        idle(xa);
        peek_reg(1, "R9 newest commit");
        chk(!peek_pending, "R9 pending cleared", 32'(peek_pending), 32'(0));
        idle(x0);
        peek_reg(1, "R9 stale result ignored");
        drain();

        // R10: source equals destination while an older writer is pending
        tick(1, 2'd0, 3'd3, 3'd3, 3'd2, -1);
        x0 = last_tag;
        tick(1, 2'd1, 3'd3, 3'd3, 3'd3, -1);
        tick(1, 2'd2, 3'd6, 3'd3, 3'd1, -1);
        idle(-1);
        idle(x0);
        drain();
        peek_all("R10 results");

        // Random program with shuffled result return
        for (int i = 0; i < 3000; i++) begin
            bit iv;
            int bs;
            iv = ($urandom_range(3) != 0);
            bs = ($urandom_range(2) == 0) ? -1 : NS;
            tick(iv, OW'($urandom_range(3)), RW'($urandom_range(NA - 1)),
                 RW'($urandom_range(NA - 1)), RW'($urandom_range(NA - 1)), bs);
        end
        drain();
        peek_all("R9 random final registers");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule